// File: doc/BRIEF.md
# Debug Control Register Unit

This unit holds the debug-side control state of a processor core and exposes it to an external debugger, and to the rest of the system, through an APB completer port. The port carries 32-bit data and decodes a 10-bit word address, which covers a 4 KB window. A separate origin input, taken from address bit 31, marks whether an access comes from the debugger or from system software. Each access takes a fixed number of wait states. An access that cannot be honoured ends with a slave error.

The register set has five words. The status/control word reports the core's halted level, the recorded reason for the most recent debug entry, a debugger-forced acknowledge bit and the two mailbox-full flags. Two mailbox words carry data between the debugger and the core: the receive mailbox is written by the debugger and drained by the core through a read strobe, and the transmit mailbox is filled by the core through a write strobe and drained by a debugger read. A power-control word drives a keep-powered output, and a power-status word shows the live power-down request input.

The unit also acknowledges an external halt request and drives two interrupt lines that report mailbox state. Interrupt-driven software can use these lines to serve the mailboxes.

Top module: `dbg_ctrl_unit`

## Requirements
- R1: Every APB access phase lasts WAIT_CYC+1 cycles (default 1 wait state). `pReady` is high only in the final cycle of the access phase and is never high in two consecutive cycles.
- R2: A read or write at a word offset above 4 completes with `pSlvErr` high and read data 0. A debugger-side read of any word offset 0 to 4 completes without error.
- R3: The following writes complete with `pSlvErr` high and change no state: any write to word 2 or word 4, and a system-side write (`pAddrDbg` low) to word 0 or word 1. Word 3 accepts writes from both sides.
- R4: Status word 0, bit 0 reads the live `coreHalted` level. Bits [5:2] record the cause of the last debug entry: 4'b0100 when `coreHalted` rises while `haltReq` is high, and 4'b0001 when it rises while `haltReq` is low. The field holds its value until the next entry and is 0 after reset.
- R5: `haltAck` is high whenever `coreHalted` is high or status bit 10 is set. Bit 10 is the only bit of word 0 that a write changes. A held `haltReq` sees `haltAck` stay high until the request is dropped.
- R6: A debugger write to word 1 stores the data on `coreRxData` and sets the receive-full flag (status bit 30). `irqRx` equals that flag. A write while the flag is full overwrites the data. A `coreRxRd` pulse clears the flag.
- R7: A `coreTxWr` pulse stores `coreTxData` and sets the transmit-full flag (status bit 29). `irqTx` is the inverse of that flag. A read of word 2 while the flag is set returns the stored data and clears the flag.
- R8: A read of word 2 while the transmit-full flag is clear returns 0 and leaves both mailbox flags unchanged.
- R9: Bit 0 of word 3 drives `noPwrDn` and reads back. Writes from either side are accepted.
- R10: Bit 0 of word 4 reads the live level of `pwrDnReq`. All other bits of word 4 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pSel | input | 1 | APB select |
| pEnable | input | 1 | APB access phase |
| pWrite | input | 1 | APB write (1) / read (0) |
| pAddrWord | input | ADDR_W | Word address, bus address bits [11:2] |
| pAddrDbg | input | 1 | Access origin: 1 debugger, 0 system (address bit 31) |
| pWData | input | DATA_W | APB write data |
| pRData | output | DATA_W | APB read data |
| pReady | output | 1 | APB transfer complete |
| pSlvErr | output | 1 | APB slave error |
| coreHalted | input | 1 | Core is in debug state |
| haltReq | input | 1 | External halt request |
| haltAck | output | 1 | Halt acknowledge |
| coreRxRd | input | 1 | Core consumes the receive mailbox |
| coreRxData | output | DATA_W | Receive mailbox contents for the core |
| coreTxWr | input | 1 | Core fills the transmit mailbox |
| coreTxData | input | DATA_W | Data for the transmit mailbox |
| irqRx | output | 1 | Receive mailbox holds data |
| irqTx | output | 1 | Transmit mailbox is free |
| noPwrDn | output | 1 | Keep-powered request |
| pwrDnReq | input | 1 | Power-down request level |

## Verification
Embedded assertions check four things on every cycle: `pReady` never stays high twice in a row, a halt entry taken under a held request records cause 0100, a receive-full flag only falls after a core read strobe, and the mailbox strobes move the interrupt lines as required. Several behaviours can only be shown by the bench's scenarios: the full decode of all 1024 word offsets, the origin-dependent write errors together with their lack of side effects, the read-side effects on the transmit mailbox, the retention of the cause field across exits, the ignored status bits and the power-control readback.

// File: rtl/dbg_ctrl_pkg.sv
`timescale 1ns/1ps
package dbg_ctrl_pkg;
  // word offsets inside the 4 KB window
  localparam int unsigned OFF_STS  = 0;
  localparam int unsigned OFF_RXMB = 1;
  localparam int unsigned OFF_TXMB = 2;
  localparam int unsigned OFF_PDC  = 3;
  localparam int unsigned OFF_PDS  = 4;
  localparam int unsigned OFF_LAST = OFF_PDS;

  // status word bit positions
  localparam int unsigned BIT_HALTED = 0;
  localparam int unsigned CAUSE_LO   = 2;
  localparam int unsigned BIT_ACKF   = 10;
  localparam int unsigned BIT_TXF    = 29;
  localparam int unsigned BIT_RXF    = 30;

  localparam logic [3:0] CAUSE_EXTREQ = 4'b0100;
  localparam logic [3:0] CAUSE_CORE   = 4'b0001;

  // strobes from the bus control to the register datapath
  typedef struct packed {
    logic stsWr;
    logic rxWr;
    logic txRd;
    logic pdWr;
  } dbgStrobes_t;
endpackage

// File: rtl/dbg_apb_ctrl.sv
`timescale 1ns/1ps
module dbg_apb_ctrl
  import dbg_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned WAIT_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddrWord,
  input  logic              pAddrDbg,
  output logic              pReady,
  output logic              pSlvErr,
  output logic              rdValid,
  output logic [2:0]        regIdx,
  output dbgStrobes_t       strb
);
  localparam int unsigned CW = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);

  logic          access;
  logic [CW-1:0] waitCnt;
  logic          hit;
  logic          wrBad;
  logic          err;
  logic          ok;

  assign access = pSel & pEnable;
  assign pReady = access & (waitCnt == CW'(WAIT_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   waitCnt <= '0;
    else if (pReady || !access)  waitCnt <= '0;
    else                         waitCnt <= waitCnt + 1'b1;
  end

  assign hit    = (pAddrWord <= ADDR_W'(OFF_LAST));
  assign regIdx = pAddrWord[2:0];
  assign wrBad  = pWrite & ((regIdx == 3'(OFF_TXMB)) | (regIdx == 3'(OFF_PDS)) |
                            (!pAddrDbg & (regIdx != 3'(OFF_PDC))));
  assign err    = !hit | wrBad;
  assign ok     = pReady & !err;

  assign pSlvErr    = pReady & err;
  assign rdValid    = ok & !pWrite;
  assign strb.stsWr = ok & pWrite & (regIdx == 3'(OFF_STS));
  assign strb.rxWr  = ok & pWrite & (regIdx == 3'(OFF_RXMB));
  assign strb.pdWr  = ok & pWrite & (regIdx == 3'(OFF_PDC));
  assign strb.txRd  = ok & !pWrite & (regIdx == 3'(OFF_TXMB));

  // R1: a completion is always followed by a non-completing cycle
  p_ready_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    pReady |=> !pReady);
endmodule

// File: rtl/dbg_regs_dp.sv
`timescale 1ns/1ps
module dbg_regs_dp
  import dbg_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dbgStrobes_t       strb,
  input  logic [2:0]        regIdx,
  input  logic [DATA_W-1:0] pWData,
  input  logic              coreHalted,
  input  logic              haltReq,
  input  logic              coreRxRd,
  input  logic              coreTxWr,
  input  logic [DATA_W-1:0] coreTxData,
  input  logic              pwrDnReq,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] coreRxData,
  output logic              haltAck,
  output logic              irqRx,
  output logic              irqTx,
  output logic              noPwrDn
);
  logic              haltedQ;
  logic [3:0]        cause;
  logic              ackForce;
  logic              rxFull;
  logic              txFull;
  logic [DATA_W-1:0] rxData;
  logic [DATA_W-1:0] txData;
  logic              pdKeep;
  logic              entry;
  logic [DATA_W-1:0] stsWord;

  assign entry = coreHalted & !haltedQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltedQ  <= 1'b0;
      cause    <= '0;
      ackForce <= 1'b0;
      pdKeep   <= 1'b0;
    end else begin
      haltedQ <= coreHalted;
      if (entry)      cause    <= haltReq ? CAUSE_EXTREQ : CAUSE_CORE;
      if (strb.stsWr) ackForce <= pWData[BIT_ACKF];
      if (strb.pdWr)  pdKeep   <= pWData[0];
    end
  end

  // mailboxes: a fill wins over a drain in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull <= 1'b0;
      txFull <= 1'b0;
      rxData <= '0;
      txData <= '0;
    end else begin
      if (strb.rxWr) begin
        rxFull <= 1'b1;
        rxData <= pWData;
      end else if (coreRxRd) begin
        rxFull <= 1'b0;
      end
      if (coreTxWr) begin
        txFull <= 1'b1;
        txData <= coreTxData;
      end else if (strb.txRd) begin
        txFull <= 1'b0;
      end
    end
  end

  always_comb begin
    stsWord                       = '0;
    stsWord[BIT_HALTED]           = coreHalted;
    stsWord[CAUSE_LO +: 4]        = cause;
    stsWord[BIT_ACKF]             = ackForce;
    stsWord[BIT_TXF]              = txFull;
    stsWord[BIT_RXF]              = rxFull;
  end

  always_comb begin
    rdData = '0;
    case (regIdx)
      3'(OFF_STS):  rdData = stsWord;
      3'(OFF_RXMB): rdData = rxData;
      3'(OFF_TXMB): rdData = txFull ? txData : '0;
      3'(OFF_PDC):  rdData[0] = pdKeep;
      3'(OFF_PDS):  rdData[0] = pwrDnReq;
      default:      rdData = '0;
    endcase
  end

  assign coreRxData = rxData;
  assign haltAck    = coreHalted | ackForce;
  assign irqRx      = rxFull;
  assign irqTx      = !txFull;
  assign noPwrDn    = pdKeep;

  // R4: entry under a held request records the external-request cause
  p_cause_ext_r4: assert property (@(posedge clk) disable iff (!rstN)
    (coreHalted && !haltedQ && haltReq) |=> (cause == CAUSE_EXTREQ));
  // R6: a debugger fill raises the receive interrupt
  p_rx_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxWr |=> irqRx);
  // R6: the receive interrupt only falls after a core read strobe
  p_rx_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!irqRx && $past(irqRx)) |-> $past(coreRxRd));
  // R7: a core fill drops the transmit interrupt
  p_tx_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    coreTxWr |=> !irqTx);
  // R8: draining an empty transmit mailbox leaves it empty
  p_tx_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqTx && strb.txRd && !coreTxWr) |=> irqTx);
endmodule

// File: rtl/dbg_ctrl_unit.sv
`timescale 1ns/1ps
module dbg_ctrl_unit
  import dbg_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WAIT_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pSel,
  input  logic              pEnable,
  input  logic              pWrite,
  input  logic [ADDR_W-1:0] pAddrWord,
  input  logic              pAddrDbg,
  input  logic [DATA_W-1:0] pWData,
  output logic [DATA_W-1:0] pRData,
  output logic              pReady,
  output logic              pSlvErr,
  input  logic              coreHalted,
  input  logic              haltReq,
  output logic              haltAck,
  input  logic              coreRxRd,
  output logic [DATA_W-1:0] coreRxData,
  input  logic              coreTxWr,
  input  logic [DATA_W-1:0] coreTxData,
  output logic              irqRx,
  output logic              irqTx,
  output logic              noPwrDn,
  input  logic              pwrDnReq
);
  dbgStrobes_t       strb;
  logic              rdValid;
  logic [2:0]        regIdx;
  logic [DATA_W-1:0] rdData;

  dbg_apb_ctrl #(.ADDR_W(ADDR_W), .WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddrWord(pAddrWord), .pAddrDbg(pAddrDbg), .pReady(pReady),
    .pSlvErr(pSlvErr), .rdValid(rdValid), .regIdx(regIdx), .strb(strb)
  );

  dbg_regs_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regIdx(regIdx), .pWData(pWData),
    .coreHalted(coreHalted), .haltReq(haltReq), .coreRxRd(coreRxRd),
    .coreTxWr(coreTxWr), .coreTxData(coreTxData), .pwrDnReq(pwrDnReq),
    .rdData(rdData), .coreRxData(coreRxData), .haltAck(haltAck),
    .irqRx(irqRx), .irqTx(irqTx), .noPwrDn(noPwrDn)
  );

  assign pRData = rdValid ? rdData : '0;
endmodule

// File: tb/test_dbg_ctrl_unit.sv
`timescale 1ns/1ps
module test_dbg_ctrl_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pSel = 0, pEnable = 0, pWrite = 0, pAddrDbg = 0;
  logic [9:0]  pAddrWord = '0;
  logic [31:0] pWData = '0;
  logic [31:0] pRData;
  logic        pReady, pSlvErr;
  logic        coreHalted = 0, haltReq = 0, coreRxRd = 0, coreTxWr = 0, pwrDnReq = 0;
  logic [31:0] coreTxData = '0;
  logic [31:0] coreRxData;
  logic        haltAck, irqRx, irqTx, noPwrDn;
  int          total = 0;
  int          bad = 0;
  logic [31:0] rd;
  bit          er;
  int          waits;

  always #2.5 clk = ~clk;

  dbg_ctrl_unit i_dbg_ctrl_unit (
    .clk(clk), .rstN(rstN), .pSel(pSel), .pEnable(pEnable), .pWrite(pWrite),
    .pAddrWord(pAddrWord), .pAddrDbg(pAddrDbg), .pWData(pWData), .pRData(pRData),
    .pReady(pReady), .pSlvErr(pSlvErr), .coreHalted(coreHalted), .haltReq(haltReq),
    .haltAck(haltAck), .coreRxRd(coreRxRd), .coreRxData(coreRxData),
    .coreTxWr(coreTxWr), .coreTxData(coreTxData), .irqRx(irqRx), .irqTx(irqTx),
    .noPwrDn(noPwrDn), .pwrDnReq(pwrDnReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb(input bit wr, input bit dbg, input int addr, input logic [31:0] wd);
    @(negedge clk);
    pSel = 1; pEnable = 0; pWrite = wr; pAddrDbg = dbg; pAddrWord = addr[9:0]; pWData = wd;
    @(negedge clk);
    pEnable = 1; waits = 0;
    forever begin
      #1;
      if (pReady) break;
      waits++;
      @(negedge clk);
    end
    rd = pRData; er = pSlvErr;
    @(negedge clk);
    pSel = 0; pEnable = 0; pWrite = 0;
  endtask

  task automatic pulse_rx_rd();
    @(negedge clk); coreRxRd = 1;
    @(negedge clk); coreRxRd = 0;
  endtask

  task automatic pulse_tx_wr(input logic [31:0] d);
    @(negedge clk); coreTxWr = 1; coreTxData = d;
    @(negedge clk); coreTxWr = 0;
  endtask

  // handshake monitor: request must persist until acknowledged, ack must persist while request held
  bit reqPrev = 0, ackSeen = 0;
  always @(negedge clk) begin
    #2;
    if (rstN) begin
      if (reqPrev && !haltReq && !ackSeen) begin
        total++; bad++;
        $display("FAIL R5: request dropped before ack, actual=0 expected=1");
      end
      if (haltReq && ackSeen && !haltAck) begin
        total++; bad++;
        $display("FAIL R5: ack fell under held request, actual=0 expected=1");
      end
      ackSeen = haltReq ? (ackSeen | haltAck) : 1'b0;
      reqPrev = haltReq;
    end
  end

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // reset state
    check("R6 reset irqRx", {31'd0, irqRx}, 0);
    check("R7 reset irqTx", {31'd0, irqTx}, 1);
    check("R5 reset haltAck", {31'd0, haltAck}, 0);
    check("R9 reset noPwrDn", {31'd0, noPwrDn}, 0);
    apb(0, 1, 0, 0);
    check("R4 reset status", rd, 32'h0);
    check("R1 wait states", waits, 1);

    // R2: full offset sweep from the debugger side
    for (int off = 0; off < 1024; off++) begin
      apb(0, 1, off, 0);
      check("R2 decode err", {31'd0, er}, {31'd0, off > 4});
      if (er) check("R2 err data", rd, 0);
      if (off < 8) check("R1 wait states", waits, 1);
    end

    // R3: system-side write sweep over low offsets, data 0
    for (int off = 0; off < 8; off++) begin
      apb(1, 0, off, 0);
      check("R3 sys write err", {31'd0, er}, {31'd0, off != 3});
    end
    apb(1, 1, 2, 32'hFFFF_FFFF);
    check("R3 dbg write word2", {31'd0, er}, 1);
    apb(1, 1, 4, 32'hFFFF_FFFF);
    check("R3 dbg write word4", {31'd0, er}, 1);
    apb(1, 0, 0, 32'h0000_0400);
    check("R3 sys status write err", {31'd0, er}, 1);
    check("R3 no ack after bad write", {31'd0, haltAck}, 0);
    apb(1, 0, 1, 32'h1111_1111);
    check("R3 sys rx write err", {31'd0, er}, 1);
    check("R3 rx untouched", {31'd0, irqRx}, 0);
    apb(0, 1, 0, 0);
    check("R3 status unchanged", rd, 0);

    // R4/R5: external halt request handshake
    @(negedge clk); haltReq = 1;
    #1 check("R5 no ack before halt", {31'd0, haltAck}, 0);
    @(negedge clk); coreHalted = 1;
    #1 check("R5 ack on halt", {31'd0, haltAck}, 1);
    repeat (2) @(negedge clk);
    apb(0, 1, 0, 0);
    check("R4 cause ext req", rd, 32'h0000_0011);
    @(negedge clk); haltReq = 0;
    @(negedge clk); coreHalted = 0;
    apb(0, 0, 0, 0);
    check("R4 cause retained", rd, 32'h0000_0010);
    check("R4 sys read ok", {31'd0, er}, 0);
    @(negedge clk); coreHalted = 1;
    repeat (2) @(negedge clk);
    apb(0, 1, 0, 0);
    check("R4 cause core", rd, 32'h0000_0005);
    @(negedge clk); coreHalted = 0;

    // R5: forced acknowledge and ignored status bits
    apb(1, 1, 0, 32'h0000_0400);
    #1 check("R5 forced ack", {31'd0, haltAck}, 1);
    apb(1, 1, 0, 32'hFFFF_FFFF);
    apb(0, 1, 0, 0);
    check("R5 only bit10 writable", rd, 32'h0000_0404);
    apb(1, 1, 0, 0);
    #1 check("R5 ack released", {31'd0, haltAck}, 0);

    // R6: receive mailbox
    apb(1, 1, 1, 32'hA5A5_0001);
    #1 check("R6 irqRx set", {31'd0, irqRx}, 1);
    check("R6 core data", coreRxData, 32'hA5A5_0001);
    apb(1, 1, 1, 32'h0000_1234);
    #1 check("R6 overwrite", coreRxData, 32'h0000_1234);
    apb(0, 1, 0, 0);
    check("R6 status bit30", rd, 32'h4000_0004);
    pulse_rx_rd();
    #1 check("R6 irqRx cleared", {31'd0, irqRx}, 0);

    // R7/R8: transmit mailbox
    apb(0, 1, 2, 0);
    check("R8 empty tx read", rd, 0);
    #1 check("R8 irqTx unchanged", {31'd0, irqTx}, 1);
    check("R8 irqRx unchanged", {31'd0, irqRx}, 0);
    pulse_tx_wr(32'hCAFE_F00D);
    #1 check("R7 irqTx low", {31'd0, irqTx}, 0);
    apb(0, 1, 0, 0);
    check("R7 status bit29", rd, 32'h2000_0004);
    apb(0, 1, 2, 0);
    check("R7 tx data", rd, 32'hCAFE_F00D);
    #1 check("R7 irqTx back", {31'd0, irqTx}, 1);
    apb(0, 1, 2, 0);
    check("R8 drained tx read", rd, 0);

    // R9/R10: power control and status
    apb(1, 0, 3, 32'h0000_0001);
    #1 check("R9 noPwrDn sys", {31'd0, noPwrDn}, 1);
    apb(0, 0, 3, 0);
    check("R9 readback", rd, 1);
    apb(1, 1, 3, 0);
    #1 check("R9 noPwrDn dbg clear", {31'd0, noPwrDn}, 0);
    @(negedge clk); pwrDnReq = 1;
    apb(0, 1, 4, 0);
    check("R10 req high", rd, 1);
    @(negedge clk); pwrDnReq = 0;
    apb(0, 1, 4, 0);
    check("R10 req low", rd, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule